// File: doc/BRIEF.md
# Two-Wide In-Order Issue Steering Unit

This block is the issue stage of an in-order pipeline with two asymmetric execution lanes: an arithmetic lane that also executes conditional branches, and a memory lane that executes loads and stores. Each cycle it is offered a 64-bit packet of two pre-decoded instructions. It decides whether both enter their lanes together, whether only the older one goes, or whether nothing issues. It then drives the read and write addresses of a register file with four read and two write ports, together with a bypass select code for every read port.

An instruction that is left behind waits in a single holdover slot and becomes the older member of the next pairing. The block enforces a one-cycle bubble after a load whose result is needed at once, and it discards wrong-path work when a branch resolves taken or when a flush is requested.

Top module: `dual_issue_pair`

## Requirements
- R1: Class codes are 0 arithmetic, 1 branch, 2 load, 3 store. Packet bits [31:0] and field low halves hold the older instruction. Arithmetic and branch instructions appear only on the arithmetic lane, and loads and stores only on the memory lane.
- R2: Two instructions issue in the same cycle when one needs each lane, in either program order, and no hazard applies.
- R3: When both candidates need the same lane, only the older one issues.
- R4: When the younger candidate reads the older one's destination (a store's data source counts as a read) or writes the same destination, only the older one issues.
- R5: A left-behind instruction is held and issues ahead of anything newer. The presented packet is not taken (ready low) while the held instruction cannot pair with it, and issue order always matches program order.
- R6: An instruction reading the destination of a load issued in the previous cycle does not issue that cycle. A stall lasts one cycle.
- R7: A branch never pairs with its younger neighbour. While br_taken_i is high nothing issues, the holdover is emptied, and a presented packet is taken and discarded.
- R8: Register 31 is never a dependency or a bypass source, and is never written (its write enable stays low).
- R9: While flush_i is high nothing issues, the presented packet is discarded, and the holdover and load history are cleared.
- R10: Read ports 0 and 1 carry the arithmetic lane's sources 1 and 2. Read ports 2 and 3 carry the memory lane's base and store data. Write port 0 is the arithmetic lane's destination, enabled for arithmetic ops. Write port 1 is the memory lane's destination, enabled for loads.
- R11: Each read port has a 2-bit bypass code at bits [2p+1:2p]. The code is 0 for the register file, 1 for the arithmetic result issued in the previous cycle, and 2 for the load issued two cycles earlier. Code 1 wins when both match, and an unused port reads 0.
- R12: After reset, nothing issues, no write enable is set and no packet is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard all pending work |
| br_taken_i | input | 1 | Branch issued earlier resolved taken |
| pkt_valid_i | input | 1 | Packet present |
| pkt_ready_o | output | 1 | Packet taken this cycle |
| pkt_word_i | input | 64 | Two instruction words, older in low half |
| pkt_cls_i | input | 4 | Class codes, older in bits [1:0] |
| pkt_rd_i | input | 10 | Destination registers |
| pkt_rs1_i | input | 10 | First source / base registers |
| pkt_rs2_i | input | 10 | Second source / store data registers |
| alu_valid_o | output | 1 | Arithmetic lane issues |
| alu_word_o | output | 32 | Instruction on arithmetic lane |
| mem_valid_o | output | 1 | Memory lane issues |
| mem_word_o | output | 32 | Instruction on memory lane |
| rf_raddr_o | output | 20 | Four read addresses, port 0 lowest |
| rf_waddr_o | output | 10 | Two write addresses |
| rf_we_o | output | 2 | Write enables |
| fwd_sel_o | output | 8 | Bypass code per read port |

## Verification
The bench runs short programs and rebuilds the issue stream from sequence numbers carried in the instruction words. It compares that stream with one-at-a-time program order and with a cycle total derived by hand. The corner cases are a packet whose older member is a memory op, same-lane pairs that force the holdover to refuse the next packet, a store whose data register is the older result, a write-after-write pair, and a load feeding either the older or only the younger instruction. A design that paired the wrong cases would issue in fewer cycles or place a dependent op beside its producer. Missing the load bubble, or stalling twice, shows up as a wrong cycle total. Further tests cover register 31 as a false dependency, bypass codes on the store-data port, a holdover surviving a taken branch or a flush, and a branch pairing with its younger neighbour; a design that got any of these wrong would show stray valid lanes or wrong codes.

// File: rtl/dip_pkg.sv
package dip_pkg;
  typedef enum logic [1:0] {
    CLS_ALU = 2'd0,
    CLS_BR  = 2'd1,
    CLS_LD  = 2'd2,
    CLS_ST  = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    FWD_RF   = 2'd0,
    FWD_ALU  = 2'd1,
    FWD_LOAD = 2'd2
  } fwd_e;

  function automatic logic is_mem(cls_e c);
    return (c == CLS_LD) || (c == CLS_ST);
  endfunction

  function automatic logic reads_b(cls_e c);
    return (c == CLS_ALU) || (c == CLS_ST);
  endfunction

  function automatic logic writes_d(cls_e c);
    return (c == CLS_ALU) || (c == CLS_LD);
  endfunction
endpackage

// File: rtl/dip_src_match.sv
module dip_src_match
  import dip_pkg::*;
#(
  parameter int RW   = 5,
  parameter int ZERO = 31
) (
  input  logic          prod_v_i,
  input  logic [RW-1:0] prod_rd_i,
  input  cls_e          cons_cls_i,
  input  logic [RW-1:0] cons_rs1_i,
  input  logic [RW-1:0] cons_rs2_i,
  output logic          hit_o
);
  logic live;
  assign live  = prod_v_i && (prod_rd_i != RW'(ZERO));
  assign hit_o = live && ((cons_rs1_i == prod_rd_i) ||
                          (reads_b(cons_cls_i) && (cons_rs2_i == prod_rd_i)));
endmodule

// File: rtl/dip_dep_chk.sv
module dip_dep_chk
  import dip_pkg::*;
#(
  parameter int RW   = 5,
  parameter int ZERO = 31
) (
  input  cls_e          a_cls_i,
  input  logic [RW-1:0] a_rd_i,
  input  cls_e          b_cls_i,
  input  logic [RW-1:0] b_rd_i,
  input  logic [RW-1:0] b_rs1_i,
  input  logic [RW-1:0] b_rs2_i,
  output logic          dep_o
);
  logic raw, waw;

  dip_src_match #(.RW(RW), .ZERO(ZERO)) u_raw (
    .prod_v_i  (writes_d(a_cls_i)),
    .prod_rd_i (a_rd_i),
    .cons_cls_i(b_cls_i),
    .cons_rs1_i(b_rs1_i),
    .cons_rs2_i(b_rs2_i),
    .hit_o     (raw)
  );

  assign waw   = writes_d(a_cls_i) && writes_d(b_cls_i) &&
                 (a_rd_i == b_rd_i) && (a_rd_i != RW'(ZERO));
  assign dep_o = raw || waw;
endmodule

// File: rtl/dip_steer.sv
module dip_steer
  import dip_pkg::*;
#(
  parameter int ILEN = 32,
  parameter int RW   = 5,
  localparam int FW  = ILEN + 2 + 3*RW,
  localparam int CLO = 3*RW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_a_i,
  input  logic          issue_b_i,
  input  logic [FW-1:0] a_i,
  input  logic [FW-1:0] b_i,
  output logic          alu_v_o,
  output logic [FW-1:0] alu_o,
  output logic          mem_v_o,
  output logic [FW-1:0] mem_o
);
  logic a_mem, b_mem;
  cls_e alu_cls, mem_cls;

  assign a_mem   = is_mem(cls_e'(a_i[CLO+1:CLO]));
  assign b_mem   = is_mem(cls_e'(b_i[CLO+1:CLO]));
  assign alu_v_o = (issue_a_i && !a_mem) || (issue_b_i && !b_mem);
  assign mem_v_o = (issue_a_i && a_mem) || (issue_b_i && b_mem);
  assign alu_o   = a_mem ? b_i : a_i;
  assign mem_o   = a_mem ? a_i : b_i;
  assign alu_cls = cls_e'(alu_o[CLO+1:CLO]);
  assign mem_cls = cls_e'(mem_o[CLO+1:CLO]);

  AST_ALU_LANE_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_v_o |-> (alu_cls == CLS_ALU || alu_cls == CLS_BR)); // R1
  AST_MEM_LANE_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_v_o |-> (mem_cls == CLS_LD || mem_cls == CLS_ST)); // R1
  AST_YOUNGER_NEEDS_OLDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_b_i |-> (issue_a_i && alu_v_o && mem_v_o)); // R5
endmodule

// File: rtl/dip_fwd_sel.sv
module dip_fwd_sel
  import dip_pkg::*;
#(
  parameter int NRP  = 4,
  parameter int RW   = 5,
  parameter int ZERO = 31
) (
  input  logic [NRP-1:0]    port_v_i,
  input  logic [NRP*RW-1:0] raddr_i,
  input  logic              alu_v_i,
  input  logic [RW-1:0]     alu_rd_i,
  input  logic              ld_v_i,
  input  logic [RW-1:0]     ld_rd_i,
  output logic [2*NRP-1:0]  sel_o
);
  for (genvar p = 0; p < NRP; p++) begin : g_port
    logic [RW-1:0] ra;
    logic hit_alu, hit_ld;
    assign ra      = raddr_i[p*RW +: RW];
    assign hit_alu = port_v_i[p] && alu_v_i && (alu_rd_i == ra) && (ra != RW'(ZERO));
    assign hit_ld  = port_v_i[p] && ld_v_i && (ld_rd_i == ra) && (ra != RW'(ZERO));
    // newer arithmetic result shadows the older load
    assign sel_o[2*p +: 2] = hit_alu ? FWD_ALU : (hit_ld ? FWD_LOAD : FWD_RF);
  end
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import dip_pkg::*;
#(
  parameter int ILEN = 32,
  parameter int NREG = 32,
  localparam int RW   = $clog2(NREG),
  localparam int ZERO = NREG - 1,
  localparam int NRP  = 4,
  localparam int NWP  = 2,
  localparam int FW   = ILEN + 2 + 3*RW,
  localparam int CLO  = 3*RW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              br_taken_i,
  input  logic              pkt_valid_i,
  output logic              pkt_ready_o,
  input  logic [2*ILEN-1:0] pkt_word_i,
  input  logic [3:0]        pkt_cls_i,
  input  logic [2*RW-1:0]   pkt_rd_i,
  input  logic [2*RW-1:0]   pkt_rs1_i,
  input  logic [2*RW-1:0]   pkt_rs2_i,
  output logic              alu_valid_o,
  output logic [ILEN-1:0]   alu_word_o,
  output logic              mem_valid_o,
  output logic [ILEN-1:0]   mem_word_o,
  output logic [NRP*RW-1:0] rf_raddr_o,
  output logic [NWP*RW-1:0] rf_waddr_o,
  output logic [NWP-1:0]    rf_we_o,
  output logic [2*NRP-1:0]  fwd_sel_o
);
  logic [FW-1:0] p0, p1, a_f, b_f, hold_q, alu_f, mem_f;
  logic          hold_v_q, a_v, b_v, squash;
  logic          luse_a, luse_b, dep, class_fit;
  logic          issue_a, issue_b, take_i1;
  cls_e          a_cls, b_cls, alu_cls, mem_cls;
  logic [RW-1:0] a_rd, a_rs1, a_rs2, b_rd, b_rs1, b_rs2;
  logic [RW-1:0] alu_rd, alu_rs1, alu_rs2, mem_rd, mem_rs1, mem_rs2;
  logic          alu_wr, mem_ld_wr;
  logic          alu_hv_q, ld1_v_q, ld2_v_q;
  logic [RW-1:0] alu_hrd_q, ld1_rd_q, ld2_rd_q;
  logic [NRP-1:0] port_v;

  assign p0 = {pkt_word_i[ILEN-1:0], pkt_cls_i[1:0], pkt_rd_i[RW-1:0],
               pkt_rs1_i[RW-1:0], pkt_rs2_i[RW-1:0]};
  assign p1 = {pkt_word_i[2*ILEN-1:ILEN], pkt_cls_i[3:2], pkt_rd_i[2*RW-1:RW],
               pkt_rs1_i[2*RW-1:RW], pkt_rs2_i[2*RW-1:RW]};

  // held instruction is always the older candidate
  assign a_f = hold_v_q ? hold_q : p0;
  assign b_f = hold_v_q ? p0 : p1;
  assign a_v = hold_v_q || pkt_valid_i;
  assign b_v = pkt_valid_i;

  assign a_cls = cls_e'(a_f[CLO+1:CLO]);
  assign a_rd  = a_f[3*RW-1:2*RW];
  assign a_rs1 = a_f[2*RW-1:RW];
  assign a_rs2 = a_f[RW-1:0];
  assign b_cls = cls_e'(b_f[CLO+1:CLO]);
  assign b_rd  = b_f[3*RW-1:2*RW];
  assign b_rs1 = b_f[2*RW-1:RW];
  assign b_rs2 = b_f[RW-1:0];

  dip_src_match #(.RW(RW), .ZERO(ZERO)) u_luse_a (
    .prod_v_i(ld1_v_q), .prod_rd_i(ld1_rd_q), .cons_cls_i(a_cls),
    .cons_rs1_i(a_rs1), .cons_rs2_i(a_rs2), .hit_o(luse_a)
  );

  dip_src_match #(.RW(RW), .ZERO(ZERO)) u_luse_b (
    .prod_v_i(ld1_v_q), .prod_rd_i(ld1_rd_q), .cons_cls_i(b_cls),
    .cons_rs1_i(b_rs1), .cons_rs2_i(b_rs2), .hit_o(luse_b)
  );

  dip_dep_chk #(.RW(RW), .ZERO(ZERO)) u_dep (
    .a_cls_i(a_cls), .a_rd_i(a_rd), .b_cls_i(b_cls), .b_rd_i(b_rd),
    .b_rs1_i(b_rs1), .b_rs2_i(b_rs2), .dep_o(dep)
  );

  assign squash    = flush_i || br_taken_i;
  assign class_fit = is_mem(a_cls) != is_mem(b_cls);
  assign issue_a   = a_v && !squash && !luse_a;
  assign issue_b   = issue_a && b_v && class_fit && !dep && !luse_b &&
                     (a_cls != CLS_BR);

  dip_steer #(.ILEN(ILEN), .RW(RW)) u_steer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .issue_a_i(issue_a),
    .issue_b_i(issue_b),
    .a_i      (a_f),
    .b_i      (b_f),
    .alu_v_o  (alu_valid_o),
    .alu_o    (alu_f),
    .mem_v_o  (mem_valid_o),
    .mem_o    (mem_f)
  );

  assign alu_cls = cls_e'(alu_f[CLO+1:CLO]);
  assign alu_rd  = alu_f[3*RW-1:2*RW];
  assign alu_rs1 = alu_f[2*RW-1:RW];
  assign alu_rs2 = alu_f[RW-1:0];
  assign mem_cls = cls_e'(mem_f[CLO+1:CLO]);
  assign mem_rd  = mem_f[3*RW-1:2*RW];
  assign mem_rs1 = mem_f[2*RW-1:RW];
  assign mem_rs2 = mem_f[RW-1:0];
  assign alu_word_o = alu_f[FW-1:CLO+2];
  assign mem_word_o = mem_f[FW-1:CLO+2];

  assign alu_wr    = alu_valid_o && (alu_cls == CLS_ALU) && (alu_rd != RW'(ZERO));
  assign mem_ld_wr = mem_valid_o && (mem_cls == CLS_LD) && (mem_rd != RW'(ZERO));

  assign rf_raddr_o = {mem_rs2, mem_rs1, alu_rs2, alu_rs1};
  assign rf_waddr_o = {mem_rd, alu_rd};
  assign rf_we_o    = {mem_ld_wr, alu_wr};

  assign port_v = {mem_valid_o && (mem_cls == CLS_ST), mem_valid_o,
                   alu_valid_o && (alu_cls == CLS_ALU), alu_valid_o};

  dip_fwd_sel #(.NRP(NRP), .RW(RW), .ZERO(ZERO)) u_fwd (
    .port_v_i(port_v),
    .raddr_i (rf_raddr_o),
    .alu_v_i (alu_hv_q),
    .alu_rd_i(alu_hrd_q),
    .ld_v_i  (ld2_v_q),
    .ld_rd_i (ld2_rd_q),
    .sel_o   (fwd_sel_o)
  );

  // packet taken: dropped on squash, else when its first member issues
  assign pkt_ready_o = squash ? 1'b1 : (hold_v_q ? issue_b : issue_a);
  assign take_i1     = hold_v_q ? issue_b : (issue_a && !issue_b);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q  <= 1'b0;
      hold_q    <= '0;
      alu_hv_q  <= 1'b0;
      alu_hrd_q <= '0;
      ld1_v_q   <= 1'b0;
      ld1_rd_q  <= '0;
      ld2_v_q   <= 1'b0;
      ld2_rd_q  <= '0;
    end else begin
      if (squash) begin
        hold_v_q <= 1'b0;
      end else if (take_i1) begin
        hold_v_q <= 1'b1;
        hold_q   <= p1;
      end else if (hold_v_q && issue_a) begin
        hold_v_q <= 1'b0;
      end
      alu_hv_q  <= alu_wr;
      alu_hrd_q <= alu_rd;
      ld1_v_q   <= mem_ld_wr;
      ld1_rd_q  <= mem_rd;
      ld2_v_q   <= flush_i ? 1'b0 : ld1_v_q;
      ld2_rd_q  <= ld1_rd_q;
    end
  end

  AST_FLUSH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (!alu_valid_o && !mem_valid_o && pkt_ready_o)); // R9
  AST_FLUSH_EMPTIES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hold_v_q); // R9
  AST_TAKEN_SQUASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken_i |-> (!alu_valid_o && !mem_valid_o)); // R7
  AST_TAKEN_EMPTIES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken_i |=> !hold_v_q); // R7
  AST_LOAD_USE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o[1] |=> !(alu_valid_o && ((alu_rs1 == $past(mem_rd)) ||
                     ((alu_cls == CLS_ALU) && (alu_rs2 == $past(mem_rd)))))); // R6
  AST_FWD_ALU_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_sel_o[1:0] == FWD_ALU) |->
      ($past(rf_we_o[0]) && ($past(rf_waddr_o[RW-1:0]) == rf_raddr_o[RW-1:0]))); // R11
  AST_NO_ZERO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o[0] |-> (rf_waddr_o[RW-1:0] != RW'(ZERO))); // R8
  AST_PAIR_DISTINCT_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&rf_we_o) |-> (rf_waddr_o[RW-1:0] != rf_waddr_o[2*RW-1:RW])); // R4
endmodule

// File: tb/test_dual_issue_pair.sv
`timescale 1ns/1ps
module test_dual_issue_pair;
  localparam time TCK = 20ns;
  localparam logic [1:0] C_ALU = 2'd0, C_BR = 2'd1, C_LD = 2'd2, C_ST = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 1'b0, br_taken = 1'b0, pkt_valid = 1'b0, pkt_ready;
  logic [63:0] pkt_word = '0;
  logic [3:0]  pkt_cls = '0;
  logic [9:0]  pkt_rd = '0, pkt_rs1 = '0, pkt_rs2 = '0;
  logic        alu_valid, mem_valid;
  logic [31:0] alu_word, mem_word;
  logic [19:0] rf_raddr;
  logic [9:0]  rf_waddr;
  logic [1:0]  rf_we;
  logic [7:0]  fwd_sel;

  int total = 0, bad = 0;
  logic done = 1'b0;

  logic [1:0] p_cls[16];
  logic [4:0] p_rd[16], p_rs1[16], p_rs2[16];
  int n;
  logic [7:0]  log_fwd[40];
  logic [19:0] log_raddr[40];
  logic [9:0]  log_waddr[40];
  logic [1:0]  log_we[40];
  logic        log_ready[40];
  logic        log_alu[40], log_mem[40];

  always #(TCK/2) clk = ~clk;

  dual_issue_pair i_dual_issue_pair (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .br_taken_i(br_taken),
    .pkt_valid_i(pkt_valid), .pkt_ready_o(pkt_ready), .pkt_word_i(pkt_word),
    .pkt_cls_i(pkt_cls), .pkt_rd_i(pkt_rd), .pkt_rs1_i(pkt_rs1), .pkt_rs2_i(pkt_rs2),
    .alu_valid_o(alu_valid), .alu_word_o(alu_word), .mem_valid_o(mem_valid),
    .mem_word_o(mem_word), .rf_raddr_o(rf_raddr), .rf_waddr_o(rf_waddr),
    .rf_we_o(rf_we), .fwd_sel_o(fwd_sel)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic set_ins(input int i, input logic [1:0] c, input logic [4:0] d,
                         input logic [4:0] s1, input logic [4:0] s2);
    p_cls[i] = c; p_rd[i] = d; p_rs1[i] = s1; p_rs2[i] = s2;
  endtask

  task automatic drive_pair(input int i);
    pkt_valid = 1'b1;
    pkt_word  = {32'hC000_0000 | 32'(i + 1), 32'hC000_0000 | 32'(i)};
    pkt_cls   = {p_cls[i+1], p_cls[i]};
    pkt_rd    = {p_rd[i+1], p_rd[i]};
    pkt_rs1   = {p_rs1[i+1], p_rs1[i]};
    pkt_rs2   = {p_rs2[i+1], p_rs2[i]};
  endtask

  task automatic check_lane(input int seq, input logic on_mem, input string req);
    logic is_m;
    is_m = (seq < 16) && (p_cls[seq] == C_LD || p_cls[seq] == C_ST);
    check(seq < 16 && is_m == on_mem, req, int'(on_mem), int'(is_m));
  endtask

  // compare issue stream against one-at-a-time program order and a cycle total
  task automatic run_prog(input int exp_cyc, input string req);
    int idx = 0, issued = 0, cyc = 0;
    while (issued < n && cyc < 40) begin
      @(negedge clk);
      if (idx < n) drive_pair(idx); else pkt_valid = 1'b0;
      #1;
      log_fwd[cyc] = fwd_sel; log_raddr[cyc] = rf_raddr; log_waddr[cyc] = rf_waddr;
      log_we[cyc] = rf_we; log_ready[cyc] = pkt_ready;
      log_alu[cyc] = alu_valid; log_mem[cyc] = mem_valid;
      cyc++;
      if (alu_valid && mem_valid) begin
        int sa = int'(alu_word[15:0]);
        int sm = int'(mem_word[15:0]);
        int lo = (sa < sm) ? sa : sm;
        int hi = (sa < sm) ? sm : sa;
        check(lo == issued && hi == issued + 1, {req, " R5 order"}, lo, issued);
        check_lane(sa, 1'b0, {req, " R1"});
        check_lane(sm, 1'b1, {req, " R1"});
        issued += 2;
      end else if (alu_valid || mem_valid) begin
        int s = alu_valid ? int'(alu_word[15:0]) : int'(mem_word[15:0]);
        check(s == issued, {req, " R5 order"}, s, issued);
        check_lane(s, mem_valid, {req, " R1"});
        issued++;
      end
      if (pkt_valid && pkt_ready) idx += 2;
    end
    check(cyc == exp_cyc && issued == n, {req, " cycles"}, cyc, exp_cyc);
  endtask

  task automatic quiet_flush();
    @(negedge clk);
    pkt_valid = 1'b0; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check(!alu_valid && !mem_valid && rf_we == 2'b00 && !pkt_ready, "R12 reset idle",
          int'({alu_valid, mem_valid, rf_we, pkt_ready}), 0);
  endtask

  task automatic t_pairs();
    quiet_flush();
    set_ins(0, C_LD, 1, 2, 0);   set_ins(1, C_ALU, 3, 4, 5);
    set_ins(2, C_ST, 0, 6, 7);   set_ins(3, C_ALU, 8, 9, 10);
    set_ins(4, C_ALU, 11, 12, 13); set_ins(5, C_LD, 14, 15, 0);
    n = 6;
    run_prog(3, "R2 mixed pairs");
    check(log_we[0] == 2'b11 && log_waddr[0] == {5'd1, 5'd3}, "R10 write ports",
          int'({log_we[0], log_waddr[0]}), int'({2'b11, 5'd1, 5'd3}));
    check(log_raddr[0] == {5'd0, 5'd2, 5'd5, 5'd4}, "R10 read ports",
          int'(log_raddr[0]), int'({5'd0, 5'd2, 5'd5, 5'd4}));
    check(log_we[1] == 2'b01, "R10 store no write", int'(log_we[1]), 1);
    check(log_fwd[0] == 8'h00, "R11 no bypass", int'(log_fwd[0]), 0);
  endtask

  task automatic t_same_lane();
    quiet_flush();
    set_ins(0, C_ALU, 1, 20, 21); set_ins(1, C_ALU, 2, 22, 23);
    set_ins(2, C_ALU, 3, 24, 25); set_ins(3, C_ALU, 4, 26, 27);
    set_ins(4, C_LD, 5, 20, 0);   set_ins(5, C_ST, 0, 21, 22);
    n = 6;
    run_prog(5, "R3 same lane");
    check(log_ready[0] && !log_ready[1], "R5 holdover refuses packet",
          int'({log_ready[0], log_ready[1]}), 2);
    check(log_ready[3], "R5 holdover pairs with packet", int'(log_ready[3]), 1);
  endtask

  task automatic t_dep();
    quiet_flush();
    set_ins(0, C_ALU, 1, 2, 3); set_ins(1, C_ST, 0, 4, 1);
    set_ins(2, C_LD, 5, 8, 0);  set_ins(3, C_ALU, 5, 6, 7);
    n = 4;
    run_prog(4, "R4 RAW and WAW");
    check(log_fwd[1] == 8'h40, "R11 store data bypass", int'(log_fwd[1]), 'h40);
    check(log_raddr[1][19:15] == 5'd1, "R10 store data port", int'(log_raddr[1][19:15]), 1);
  endtask

  task automatic t_load_use();
    quiet_flush();
    set_ins(0, C_LD, 1, 2, 0); set_ins(1, C_ALU, 3, 1, 4);
    n = 2;
    run_prog(3, "R6 older load use");
    check(!log_alu[1] && !log_mem[1] && !log_ready[1], "R6 bubble",
          int'({log_alu[1], log_mem[1]}), 0);
    check(log_fwd[2] == 8'h02, "R11 load bypass", int'(log_fwd[2]), 2);
    quiet_flush();
    set_ins(0, C_LD, 1, 2, 0);  set_ins(1, C_ALU, 5, 6, 7);
    set_ins(2, C_ALU, 6, 7, 8); set_ins(3, C_ST, 0, 1, 9);
    n = 4;
    run_prog(3, "R6 younger load use");
    check(log_alu[1] && !log_mem[1], "R6 younger held", int'({log_alu[1], log_mem[1]}), 2);
    check(log_fwd[2] == 8'h20, "R11 base bypass", int'(log_fwd[2]), 'h20);
  endtask

  task automatic t_zero();
    quiet_flush();
    set_ins(0, C_LD, 31, 2, 0);  set_ins(1, C_ALU, 3, 31, 31);
    set_ins(2, C_ALU, 4, 31, 5); set_ins(3, C_ST, 0, 31, 31);
    n = 4;
    run_prog(2, "R8 zero register");
    check(log_we[0] == 2'b01, "R8 no write to r31", int'(log_we[0]), 1);
    check(log_fwd[1] == 8'h00, "R8 no r31 bypass", int'(log_fwd[1]), 0);
  endtask

  task automatic t_branch();
    quiet_flush();
    set_ins(0, C_BR, 0, 1, 0); set_ins(1, C_ST, 0, 2, 3);
    n = 2;
    run_prog(2, "R7 branch not paired");
    quiet_flush();
    set_ins(0, C_ST, 0, 2, 3); set_ins(1, C_BR, 0, 4, 0);
    n = 2;
    run_prog(1, "R2 younger branch pairs");
    quiet_flush();
    set_ins(0, C_BR, 0, 1, 0); set_ins(1, C_ST, 0, 2, 3);
    set_ins(2, C_ALU, 9, 1, 2); set_ins(3, C_LD, 10, 3, 0);
    @(negedge clk); drive_pair(0); #1;
    check(alu_valid && !mem_valid, "R7 branch alone", int'({alu_valid, mem_valid}), 2);
    @(negedge clk); drive_pair(2); br_taken = 1'b1; #1;
    check(!alu_valid && !mem_valid && pkt_ready, "R7 taken squash",
          int'({alu_valid, mem_valid, pkt_ready}), 1);
    @(negedge clk); pkt_valid = 1'b0; br_taken = 1'b0; #1;
    check(!alu_valid && !mem_valid, "R7 holdover dropped", int'({alu_valid, mem_valid}), 0);
  endtask

  task automatic t_flush();
    quiet_flush();
    set_ins(0, C_ALU, 1, 2, 3); set_ins(1, C_ALU, 4, 5, 6);
    set_ins(2, C_LD, 7, 8, 0);  set_ins(3, C_ST, 0, 9, 10);
    @(negedge clk); drive_pair(0); #1;
    check(alu_valid && !mem_valid, "R3 first of same lane", int'({alu_valid, mem_valid}), 2);
    @(negedge clk); drive_pair(2); flush = 1'b1; #1;
    check(!alu_valid && !mem_valid && pkt_ready, "R9 flush quiet",
          int'({alu_valid, mem_valid, pkt_ready}), 1);
    @(negedge clk); flush = 1'b0; pkt_valid = 1'b0; #1;
    check(!alu_valid && !mem_valid, "R9 holdover cleared", int'({alu_valid, mem_valid}), 0);
  endtask

  initial begin
    #(TCK * 5000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_pairs();
    t_same_lane();
    t_dep();
    t_load_use();
    t_zero();
    t_branch();
    t_flush();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule